// File: doc/BRIEF.md
# Gated Timer/Counter Pair

This block holds two independent 16-bit timer/counter channels behind a byte-wide register bus. A single 8-bit mode register sets up both channels. For each channel it picks the increment source and says whether an external gate pin qualifies counting. In timer operation a channel advances once every twelve clocks, using a free-running divide-by-twelve prescaler that both channels share. In counter operation the channel advances once for each high-to-low transition on its event pin.

A channel counts only while its run bit is set. When gating is enabled for that channel, its gate pin must also be high. The event and gate pins are asynchronous, so each one passes through a two-flop synchronizer before it is used. Each channel has two count layouts. One is a full 16-bit up-count. The other is an 8-bit low-byte count that reloads from the high byte when it wraps. Both layouts raise a sticky overflow flag, and that flag stays set until software writes it back to zero.

Top module: `tmr_pair`

## Requirements
- R1: After reset the mode register, the run bits, both overflow flags and both counts read as zero.
- R2: The mode register sits at address 0x89 and reads back what was written. Bits 3:0 configure channel 0 and bits 7:4 configure channel 1. Within each nibble, bit 3 is the gate enable, bit 2 is the source select, and bits 1:0 are the count layout. Writes to other addresses leave the mode register unchanged.
- R3: With source select 0, a running channel advances by exactly one for every twelve clock cycles it stays enabled.
- R4: With source select 1, a running channel advances by exactly one for each falling edge on its event pin. Rising edges have no effect.
- R5: With gate enable 0, the gate pin level has no effect on counting.
- R6: With gate enable 1 and the run bit set, the channel counts while its gate pin is high and holds its value while the pin is low.
- R7: A channel whose run bit is 0 holds its count whatever its event and gate pins do. The control register is at 0x88: bit 0 is the channel-0 run bit and bit 1 is the channel-1 run bit.
- R8: Layout 01 counts all 16 bits. A wrap from 0xFFFF to 0x0000 sets the channel's overflow flag, which shows on ovf_flag and in control-register bits 4 (channel 0) and 5 (channel 1). The flag stays set until a control write puts a 0 in that bit.
- R9: Layout 10 counts only the low byte. When the low byte would pass 0xFF it is loaded from the high byte instead, and the overflow flag is set. The high byte is untouched.
- R10: A bus write to a count byte takes priority over an increment in the same cycle. The count bytes are low byte at 0x8A (channel 0) and 0x8B (channel 1), and high byte at 0x8C (channel 0) and 0x8D (channel 1).
- R11: The two channels are independent. Events, configuration and counting on one channel never change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 8 | Register address for both writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| evt_in | input | 2 | Asynchronous event pins, one per channel |
| gate_in | input | 2 | Asynchronous gate pins, one per channel |
| ovf_flag | output | 2 | Sticky overflow flags, one per channel |

## Verification
A register write becomes visible on reg_rdata just after the edge that captures it. An event pin edge reaches the count on the third rising clock edge after the pin changes: two edges for the synchronizer and one for the count register. A gate change needs two edges before it takes effect. Every stimulus in the bench is therefore followed by at least four idle cycles before the bench reads back. Timer-mode checks do not depend on the prescaler phase: the bench sets the run bit and clears it exactly 120 edges later, a window that contains exactly ten prescaler ticks. The write-priority check reads the count on the clock phase right after each back-to-back write.

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int         CW     = 16,
  parameter int         DIV    = 12,
  parameter logic [7:0] A_CTRL = 8'h88,
  parameter logic [7:0] A_MODE = 8'h89,
  parameter logic [7:0] A_LO   = 8'h8A,
  parameter logic [7:0] A_HI   = 8'h8C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] evt_in,
  input  logic [1:0] gate_in,
  output logic [1:0] ovf_flag
);
  localparam int PW = $clog2(DIV);
  localparam int HW = CW / 2;
  localparam int NCH = 2;

  logic [7:0]       mode_q;
  logic [NCH-1:0]   run_q;
  logic [PW-1:0]    pre_q;
  logic [NCH*CW-1:0] cnt_all;

  wire tick    = (pre_q == PW'(DIV - 1));
  wire wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  wire wr_mode = reg_wr && (reg_addr == A_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      pre_q  <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_ctrl) run_q  <= reg_wdata[NCH-1:0];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic          e1, e2, ed, g1, g2, ovf;
    logic [CW-1:0] cnt;

    wire       gate_en = mode_q[4*ch+3];
    wire       ct      = mode_q[4*ch+2];
    wire [1:0] md      = mode_q[4*ch +: 2];
    wire       fall    = ed & ~e2;
    wire       enable  = run_q[ch] & (~gate_en | g2);
    wire       inc     = enable & (ct ? fall : tick);
    wire       wr_lo   = reg_wr && (reg_addr == A_LO + 8'(ch));
    wire       wr_hi   = reg_wr && (reg_addr == A_HI + 8'(ch));
    wire       short   = (md == 2'b10);
    wire       wrap    = short ? &cnt[HW-1:0] : &cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        {e1, e2, ed, g1, g2} <= '0;
        cnt <= '0;
        ovf <= 1'b0;
      end else begin
        e1 <= evt_in[ch];
        e2 <= e1;
        ed <= e2;
        g1 <= gate_in[ch];
        g2 <= g1;
        if (wr_lo)
          cnt[HW-1:0] <= reg_wdata;
        else if (wr_hi)
          cnt[CW-1:HW] <= reg_wdata;
        else if (inc) begin
          if (short)
            cnt[HW-1:0] <= wrap ? cnt[CW-1:HW] : cnt[HW-1:0] + 1'b1;
          else
            cnt <= cnt + 1'b1;
        end
        if (inc && wrap && !wr_lo && !wr_hi)
          ovf <= 1'b1;
        else if (wr_ctrl)
          ovf <= reg_wdata[4+ch];
      end
    end

    assign cnt_all[CW*ch +: CW] = cnt;
    assign ovf_flag[ch] = ovf;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL:        reg_rdata = {2'b00, ovf_flag, 2'b00, run_q};
      A_MODE:        reg_rdata = mode_q;
      A_LO:          reg_rdata = cnt_all[HW-1:0];
      A_LO + 8'd1:   reg_rdata = cnt_all[CW+HW-1:CW];
      A_HI:          reg_rdata = cnt_all[CW-1:HW];
      A_HI + 8'd1:   reg_rdata = cnt_all[2*CW-1:CW+HW];
      default:       reg_rdata = '0;
    endcase
  end
endmodule

module tmr_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [7:0]  mode_q,
  input logic [1:0]  run_q,
  input logic [1:0]  ovf_flag,
  input logic [31:0] cnt_all
);
  wire wr_c0 = reg_wr && (reg_addr == 8'h8A || reg_addr == 8'h8C);
  wire wr_c1 = reg_wr && (reg_addr == 8'h8B || reg_addr == 8'h8D);
  wire wr_ct = reg_wr && (reg_addr == 8'h88);
  wire [15:0] c0 = cnt_all[15:0];
  wire [15:0] c1 = cnt_all[31:16];

  // R7
  idle0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !wr_c0) |=> $stable(c0));
  // R7
  idle1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[1] && !wr_c1) |=> $stable(c1));
  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag[0] && !wr_ct) |=> ovf_flag[0]);
  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b01 && !wr_c0) |=> (c0 == $past(c0) || c0 == $past(c0) + 16'd1));
  // R9
  reload_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b10 && !wr_c0) |=> $stable(c0[15:8]));
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 8'h89) |=> $stable(mode_q));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .mode_q(mode_q), .run_q(run_q), .ovf_flag(ovf_flag), .cnt_all(cnt_all)
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0, reg_wr = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic [1:0] evt_in = 2'b11, gate_in = 2'b11, ovf_flag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_pair u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .gate_in(gate_in), .ovf_flag(ovf_flag));

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd16(input int ch, output logic [15:0] v);
    logic [7:0] h, l;
    rd(8'h8C + 8'(ch), h);
    rd(8'h8A + 8'(ch), l);
    v = {h, l};
  endtask

  task automatic clr(input int ch);
    wr(8'h8A + 8'(ch), 8'h00);
    wr(8'h8C + 8'(ch), 8'h00);
  endtask

  task automatic pulse(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      evt_in[ch] = 1'b0; repeat (3) @(negedge clk);
      evt_in[ch] = 1'b1; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [15:0] v;
    rd(8'h88, d); chk("R1 ctrl", 16'(d), 16'h0);
    rd(8'h89, d); chk("R1 mode", 16'(d), 16'h0);
    rd16(0, v);   chk("R1 cnt0", v, 16'h0);
    rd16(1, v);   chk("R1 cnt1", v, 16'h0);
    chk("R1 ovf", 16'(ovf_flag), 16'h0);
  endtask

  task automatic t_mode_reg;
    logic [7:0] d;
    wr(8'h89, 8'hA5); rd(8'h89, d); chk("R2 readback", 16'(d), 16'hA5);
    wr(8'h88, 8'h00); rd(8'h89, d); chk("R2 hold", 16'(d), 16'hA5);
    wr(8'h89, 8'h00);
  endtask

  task automatic t_timer;
    logic [15:0] v;
    wr(8'h89, 8'h01); clr(0);
    wr(8'h88, 8'h01);
    repeat (119) @(negedge clk);
    wr(8'h88, 8'h00);
    rd16(0, v); chk("R3 ten ticks in 120 cycles", v, 16'd10);
    repeat (60) @(negedge clk);
    rd16(0, v); chk("R7 timer stopped", v, 16'd10);
  endtask

  task automatic t_counter;
    logic [15:0] v;
    wr(8'h89, 8'h05); clr(0); wr(8'h88, 8'h01);
    pulse(0, 5);
    rd16(0, v); chk("R4 five falls", v, 16'd5);
    wr(8'h88, 8'h00);
  endtask

  task automatic t_gate_off;
    logic [15:0] v;
    gate_in[0] = 1'b0;
    wr(8'h89, 8'h05); clr(0); wr(8'h88, 8'h01);
    pulse(0, 3);
    rd16(0, v); chk("R5 gate ignored", v, 16'd3);
    wr(8'h88, 8'h00);
  endtask

  task automatic t_gate_on;
    logic [15:0] v;
    gate_in[0] = 1'b0;
    wr(8'h89, 8'h0D); clr(0); wr(8'h88, 8'h01);
    repeat (4) @(negedge clk);
    pulse(0, 4);
    rd16(0, v); chk("R6 gate low holds", v, 16'd0);
    gate_in[0] = 1'b1; repeat (4) @(negedge clk);
    pulse(0, 3);
    rd16(0, v); chk("R6 gate high counts", v, 16'd3);
    gate_in[0] = 1'b0; repeat (4) @(negedge clk);
    pulse(0, 2);
    rd16(0, v); chk("R6 gate low again", v, 16'd3);
    wr(8'h88, 8'h00); gate_in[0] = 1'b1;
  endtask

  task automatic t_run_off;
    logic [15:0] v;
    wr(8'h89, 8'h05); clr(0); wr(8'h88, 8'h00);
    pulse(0, 3);
    rd16(0, v); chk("R7 run off", v, 16'd0);
  endtask

  task automatic t_wrap16;
    logic [15:0] v; logic [7:0] d;
    wr(8'h89, 8'h05); wr(8'h8A, 8'hFE); wr(8'h8C, 8'hFF); wr(8'h88, 8'h01);
    pulse(0, 2);
    rd16(0, v); chk("R8 wrap value", v, 16'h0000);
    chk("R8 ovf set", 16'(ovf_flag[0]), 16'd1);
    rd(8'h88, d); chk("R8 ctrl ovf bit", 16'(d[4]), 16'd1);
    pulse(0, 1);
    rd16(0, v); chk("R8 after wrap", v, 16'h0001);
    chk("R8 ovf sticky", 16'(ovf_flag[0]), 16'd1);
    wr(8'h88, 8'h01); @(negedge clk);
    chk("R8 ovf cleared", 16'(ovf_flag[0]), 16'd0);
    wr(8'h88, 8'h00);
  endtask

  task automatic t_reload;
    logic [15:0] v;
    wr(8'h89, 8'h06); wr(8'h8A, 8'hFE); wr(8'h8C, 8'h40); wr(8'h88, 8'h01);
    pulse(0, 1);
    rd16(0, v); chk("R9 pre-wrap", v, 16'h40FF);
    chk("R9 no ovf yet", 16'(ovf_flag[0]), 16'd0);
    pulse(0, 1);
    rd16(0, v); chk("R9 reload", v, 16'h4040);
    chk("R9 ovf set", 16'(ovf_flag[0]), 16'd1);
    wr(8'h88, 8'h00);
  endtask

  task automatic t_write_prio;
    int bad = 0;
    wr(8'h89, 8'h01); clr(0); wr(8'h88, 8'h01);
    for (int i = 0; i < 24; i++) begin
      reg_wr = 1; reg_addr = 8'h8A; reg_wdata = 8'(8'h10 + i);
      @(negedge clk);
      reg_wr = 0;
      #1 if (reg_rdata !== 8'(8'h10 + i)) bad++;
    end
    chk("R10 write wins over tick", 16'(bad), 16'd0);
    wr(8'h88, 8'h00);
  endtask

  task automatic t_indep;
    logic [15:0] v;
    wr(8'h89, 8'h55); clr(0); clr(1); wr(8'h88, 8'h03);
    pulse(1, 3);
    rd16(1, v); chk("R11 ch1 counts", v, 16'd3);
    rd16(0, v); chk("R11 ch0 untouched", v, 16'd0);
    pulse(0, 2);
    rd16(0, v); chk("R11 ch0 counts", v, 16'd2);
    rd16(1, v); chk("R11 ch1 untouched", v, 16'd3);
    chk("R11 ch1 no ovf", 16'(ovf_flag[1]), 16'd0);
    wr(8'h88, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_mode_reg;
    t_timer;
    t_counter;
    t_gate_off;
    t_gate_on;
    t_run_off;
    t_wrap16;
    t_reload;
    t_write_prio;
    t_indep;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule